// File: doc/BRIEF.md
# Wide Register Bridge over a Management Bus

This block sits on the host side of a management bus. It accepts 32-bit register requests (read, write and read-modify-write) and turns each one into a fixed, ordered series of single 16-bit management transactions. These transactions go to a switch device at a configurable bus address. Before each wide access the block selects the device's bridge page, which is page 4, by writing page register 31. It then moves the 32-bit address and data through a set of 16-bit window registers.

The same request port also carries plain 16-bit PHY reads and writes. The device's PHY can share the switch's bus address. For that reason the block remembers the last page it wrote. When a PHY access targets the shared address while the bridge page is still selected, the block first switches that address back to page 0. A request is taken only while `req_ready` is high. Each accepted request ends with a single `rsp_done` pulse, which carries an error flag and any read data.

Top module: `mgmt_wide_bridge`

## Requirements
- R1: After reset the block has `req_ready`=1, `mg_valid`=0 and `rsp_done`=0. The remembered page is 0, so a first PHY access to `sw_addr` issues exactly one transaction.
- R2: Opcodes on `req_op` are 0 = wide read, 1 = wide write, 2 = masked update, 3 = PHY read and 4 = PHY write. Every wide request (0, 1, 2) first writes value 4 to register 31 at `sw_addr`.
- R3: A wide write then issues five writes in this order: reg 0x10 = 0, reg 0x11 = address[31:16], reg 0x12 = address[15:0], reg 0x13 = data[31:16], reg 0x14 = data[15:0]. The total is 6 transactions.
- R4: A wide read then issues writes to reg 0x10 = 0, reg 0x15 = address[31:16] and reg 0x16 = address[15:0]. It follows with a read of 0x17 and a read of 0x18. `rsp_rdata` = {value from 0x17, value from 0x18}.
- R5: A masked update runs the wide-read steps, then the wide-write steps without a second page write, for 11 transactions in total. The value written is (old AND NOT `req_mask`) OR `req_wdata`.
- R6: A transaction answered with `mg_err`=1 ends the request. No further transaction is issued, and `rsp_done` arrives with `rsp_err`=1. This also holds when the failing transaction is the last one.
- R7: A PHY access with PHY address equal to `sw_addr` while the remembered page is 4 first writes 0 to register 31 at `sw_addr`. After that the remembered page is 0, so the next such access issues a single transaction.
- R8: A PHY access to any other address is sent as one transaction and leaves the remembered page unchanged.
- R9: For PHY requests, `req_addr[9:5]` is the PHY address and `req_addr[4:0]` is the register. Write data is `req_wdata[15:0]`. Read data returns in `rsp_rdata[15:0]` with bits 31:16 zero.
- R10: `req_ready` is low from acceptance until the response. `mg_valid` and its fields hold steady until `mg_done`.
- R11: `rsp_done` is a single-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_addr | input | 5 | Bus address of the switch device |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 3 | Request opcode (see R2) |
| req_addr | input | 32 | Wide register address, or PHY address/register fields |
| req_wdata | input | 32 | Write data, or new bits for an update |
| req_mask | input | 32 | Bits cleared before the OR of an update |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request aborted by a failed transaction |
| rsp_rdata | output | 32 | Read result |
| mg_valid | output | 1 | Management transaction requested |
| mg_write | output | 1 | 1 = write, 0 = read |
| mg_phy | output | 5 | Transaction bus address |
| mg_reg | output | 5 | Transaction register number |
| mg_wdata | output | 16 | Transaction write data |
| mg_done | input | 1 | Transaction completed (one pulse) |
| mg_err | input | 1 | Transaction failed, valid with mg_done |
| mg_rdata | input | 16 | Transaction read data, valid with mg_done |

## Verification
Abort and normal completion can land in the same cycle when the failing transaction is the final step of a sequence. The bench provokes this by failing the sixth transaction of a wide read, which is the read of register 0x18. It then expects exactly six logged transactions, one `rsp_done` pulse, and `rsp_err` set. Aborts earlier in a write and in the read half of an update are also injected. A later wide read must then show that the stored word was never changed.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int PAGE_W  = 3;
    localparam int MAX_STEPS = 11;
    localparam int IDX_W   = $clog2(MAX_STEPS + 1);

    localparam logic [REG_AW-1:0] REG_PAGE   = 5'd31;
    localparam logic [REG_AW-1:0] REG_MODE   = 5'h10;
    localparam logic [REG_AW-1:0] REG_WA_HI  = 5'h11;
    localparam logic [REG_AW-1:0] REG_WA_LO  = 5'h12;
    localparam logic [REG_AW-1:0] REG_WD_HI  = 5'h13;
    localparam logic [REG_AW-1:0] REG_WD_LO  = 5'h14;
    localparam logic [REG_AW-1:0] REG_RA_HI  = 5'h15;
    localparam logic [REG_AW-1:0] REG_RA_LO  = 5'h16;
    localparam logic [REG_AW-1:0] REG_RD_HI  = 5'h17;
    localparam logic [REG_AW-1:0] REG_RD_LO  = 5'h18;

    localparam logic [PAGE_W-1:0] PAGE_STD    = 3'd0;
    localparam logic [PAGE_W-1:0] PAGE_BRIDGE = 3'd4;

    typedef enum logic [2:0] {
        OP_RD32   = 3'd0,
        OP_WR32   = 3'd1,
        OP_UPD32  = 3'd2,
        OP_PHY_RD = 3'd3,
        OP_PHY_WR = 3'd4
    } op_e;

    typedef struct packed {
        logic              write;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regn;
        logic [HALF_W-1:0] wdata;
        logic              last;
        logic              cap_hi;
        logic              cap_lo;
        logic              page_wr;
    } step_t;

    function automatic logic is_phy_op(input logic [2:0] op);
        return (op == OP_PHY_RD) || (op == OP_PHY_WR);
    endfunction

    function automatic step_t mk_wr(input logic [PHY_AW-1:0] phy,
                                    input logic [REG_AW-1:0] regn,
                                    input logic [HALF_W-1:0] data);
        step_t s;
        s = '0;
        s.write = 1'b1;
        s.phy   = phy;
        s.regn  = regn;
        s.wdata = data;
        return s;
    endfunction

    function automatic step_t mk_rd(input logic [PHY_AW-1:0] phy,
                                    input logic [REG_AW-1:0] regn);
        step_t s;
        s = '0;
        s.phy  = phy;
        s.regn = regn;
        return s;
    endfunction

    function automatic step_t mk_page(input logic [PHY_AW-1:0] phy,
                                      input logic [PAGE_W-1:0] page);
        step_t s;
        s = mk_wr(phy, REG_PAGE, {{(HALF_W-PAGE_W){1'b0}}, page});
        s.page_wr = 1'b1;
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old,
                                                     input logic [WORD_W-1:0] mask,
                                                     input logic [WORD_W-1:0] nv);
        return (old & ~mask) | nv;
    endfunction

endpackage

// File: rtl/mwb_page_cache.sv
module mwb_page_cache
    import mwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [PAGE_W-1:0] new_page,
    input  logic [PHY_AW-1:0] probe_phy,
    input  logic [PHY_AW-1:0] sw_addr,
    output logic [PAGE_W-1:0] page_q,
    output logic              restore_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= PAGE_STD;
        end else if (upd) begin
            page_q <= new_page;
        end
    end

    assign restore_req = (probe_phy == sw_addr) && (page_q == PAGE_BRIDGE);

    // R7: only the standard and bridge pages are ever recorded
    p_page_legal_r7: assert property (@(posedge clk) disable iff (rst)
        (page_q == PAGE_STD) || (page_q == PAGE_BRIDGE));

endmodule

// File: rtl/mwb_step_gen.sv
module mwb_step_gen
    import mwb_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [PHY_AW-1:0] sw_addr,
    output step_t             step
);

    logic [WORD_W-1:0] merged;
    assign merged = merge_word(rd_word, mask, wdata);

    always_comb begin
        step = '0;
        if (is_phy_op(op)) begin
            if (idx == '0) begin
                step = mk_page(sw_addr, PAGE_STD);
            end else if (op == OP_PHY_WR) begin
                step = mk_wr(addr[PHY_AW+REG_AW-1:REG_AW], addr[REG_AW-1:0], wdata[HALF_W-1:0]);
                step.last = 1'b1;
            end else begin
                step = mk_rd(addr[PHY_AW+REG_AW-1:REG_AW], addr[REG_AW-1:0]);
                step.cap_lo = 1'b1;
                step.last   = 1'b1;
            end
        end else if (op == OP_WR32) begin
            case (idx)
                4'd0:    step = mk_page(sw_addr, PAGE_BRIDGE);
                4'd1:    step = mk_wr(sw_addr, REG_MODE, '0);
                4'd2:    step = mk_wr(sw_addr, REG_WA_HI, addr[WORD_W-1:HALF_W]);
                4'd3:    step = mk_wr(sw_addr, REG_WA_LO, addr[HALF_W-1:0]);
                4'd4:    step = mk_wr(sw_addr, REG_WD_HI, wdata[WORD_W-1:HALF_W]);
                default: begin
                    step = mk_wr(sw_addr, REG_WD_LO, wdata[HALF_W-1:0]);
                    step.last = 1'b1;
                end
            endcase
        end else begin
            case (idx)
                4'd0: step = mk_page(sw_addr, PAGE_BRIDGE);
                4'd1: step = mk_wr(sw_addr, REG_MODE, '0);
                4'd2: step = mk_wr(sw_addr, REG_RA_HI, addr[WORD_W-1:HALF_W]);
                4'd3: step = mk_wr(sw_addr, REG_RA_LO, addr[HALF_W-1:0]);
                4'd4: begin
                    step = mk_rd(sw_addr, REG_RD_HI);
                    step.cap_hi = 1'b1;
                end
                4'd5: begin
                    step = mk_rd(sw_addr, REG_RD_LO);
                    step.cap_lo = 1'b1;
                    step.last   = (op != OP_UPD32);
                end
                4'd6: step = mk_wr(sw_addr, REG_MODE, '0);
                4'd7: step = mk_wr(sw_addr, REG_WA_HI, addr[WORD_W-1:HALF_W]);
                4'd8: step = mk_wr(sw_addr, REG_WA_LO, addr[HALF_W-1:0]);
                4'd9: step = mk_wr(sw_addr, REG_WD_HI, merged[WORD_W-1:HALF_W]);
                default: begin
                    step = mk_wr(sw_addr, REG_WD_LO, merged[HALF_W-1:0]);
                    step.last = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/mgmt_wide_bridge.sv
module mgmt_wide_bridge
    import mwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PHY_AW-1:0] sw_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] req_mask,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mg_valid,
    output logic              mg_write,
    output logic [PHY_AW-1:0] mg_phy,
    output logic [REG_AW-1:0] mg_reg,
    output logic [HALF_W-1:0] mg_wdata,
    input  logic              mg_done,
    input  logic              mg_err,
    input  logic [HALF_W-1:0] mg_rdata
);

    typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} state_e;

    state_e            st;
    logic [2:0]        op_q;
    logic [WORD_W-1:0] addr_q, wdata_q, mask_q, rd_q;
    logic [IDX_W-1:0]  idx_q;
    logic              err_q;
    step_t             step;
    logic [PAGE_W-1:0] page_q;
    logic              restore_req;
    logic              fin;

    mwb_step_gen u_step (
        .op      (op_q),
        .idx     (idx_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .mask    (mask_q),
        .rd_word (rd_q),
        .sw_addr (sw_addr),
        .step    (step)
    );

    mwb_page_cache u_page (
        .clk         (clk),
        .rst         (rst),
        .upd         (fin && step.page_wr),
        .new_page    (step.wdata[PAGE_W-1:0]),
        .probe_phy   (req_addr[PHY_AW+REG_AW-1:REG_AW]),
        .sw_addr     (sw_addr),
        .page_q      (page_q),
        .restore_req (restore_req)
    );

    assign fin       = (st == S_BUSY) && mg_done;
    assign req_ready = (st == S_IDLE);
    assign rsp_done  = (st == S_RESP);
    assign rsp_err   = err_q;
    assign rsp_rdata = rd_q;
    assign mg_valid  = (st == S_BUSY);
    assign mg_write  = step.write;
    assign mg_phy    = step.phy;
    assign mg_reg    = step.regn;
    assign mg_wdata  = step.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            rd_q    <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    op_q    <= req_op;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    mask_q  <= req_mask;
                    rd_q    <= '0;
                    err_q   <= 1'b0;
                    idx_q   <= (is_phy_op(req_op) && !restore_req) ? IDX_W'(1) : '0;
                    st      <= S_BUSY;
                end
                S_BUSY: if (mg_done) begin
                    if (mg_err) begin
                        err_q <= 1'b1;
                        st    <= S_RESP;
                    end else begin
                        if (step.cap_hi) rd_q[WORD_W-1:HALF_W] <= mg_rdata;
                        if (step.cap_lo) rd_q[HALF_W-1:0]      <= mg_rdata;
                        if (step.last) st <= S_RESP;
                        else           idx_q <= idx_q + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2: a wide request opens with the bridge page select at the switch address
    p_page_first_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(mg_valid) && !is_phy_op(op_q)) |->
        (mg_write && mg_reg == REG_PAGE && mg_phy == sw_addr && mg_wdata == 16'd4));

    // R7: shared-address PHY access with bridge page cached opens with a page-0 write
    p_restore_first_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(mg_valid) && is_phy_op(op_q) && addr_q[9:5] == sw_addr && page_q == PAGE_BRIDGE) |->
        (mg_write && mg_reg == REG_PAGE && mg_wdata == 16'd0));

    // R6: nothing further is issued after a failed transaction
    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_done && mg_err) |=> !mg_valid);

    // R10: transaction fields hold until completion
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && !mg_done) |=> (mg_valid && $stable(mg_reg) && $stable(mg_phy)
                                    && $stable(mg_wdata) && $stable(mg_write)));

    // R10: no request is taken while a transaction is outstanding
    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mg_valid |-> !req_ready);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sim_mgmt_wide_bridge.sv
module sim_mgmt_wide_bridge;

    localparam logic [4:0] SW = 5'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0, req_wdata = '0, req_mask = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mg_valid, mg_write;
    logic [4:0]  mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_done = 1'b0, mg_err = 1'b0;
    logic [15:0] mg_rdata = '0;

    always #10 clk = ~clk;

    mgmt_wide_bridge u0 (
        .clk(clk), .rst(rst), .sw_addr(SW),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mg_valid(mg_valid), .mg_write(mg_write), .mg_phy(mg_phy),
        .mg_reg(mg_reg), .mg_wdata(mg_wdata),
        .mg_done(mg_done), .mg_err(mg_err), .mg_rdata(mg_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // device model: pages, wide memory, PHY registers, transaction log
    logic [2:0]  page_m [0:31];
    logic [15:0] phyreg [0:31][0:31];
    logic [31:0] mem [logic [31:0]];
    logic [15:0] wah, wal, wdh, rah, ral;
    logic        lg_w   [0:15];
    logic [4:0]  lg_phy [0:15];
    logic [4:0]  lg_reg [0:15];
    logic [15:0] lg_dat [0:15];
    int          log_n = 0;
    int          err_at = 0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    initial begin
        for (int p = 0; p < 32; p++) begin
            page_m[p] = 3'd0;
            for (int r = 0; r < 32; r++) phyreg[p][r] = 16'h0;
        end
        forever begin
            @(negedge clk);
            if (mg_done) begin
                mg_done = 1'b0;
                mg_err  = 1'b0;
            end else if (mg_valid) begin
                if (log_n < 16) begin
                    lg_w[log_n] = mg_write; lg_phy[log_n] = mg_phy;
                    lg_reg[log_n] = mg_reg; lg_dat[log_n] = mg_wdata;
                end
                log_n++;
                mg_done = 1'b1;
                mg_rdata = 16'h0;
                if (log_n == err_at) begin
                    mg_err = 1'b1;
                end else if (mg_write) begin
                    if (mg_reg == 5'd31) page_m[mg_phy] = mg_wdata[2:0];
                    else if (mg_phy == SW && page_m[mg_phy] == 3'd4) begin
                        case (mg_reg)
                            5'h11: wah = mg_wdata;
                            5'h12: wal = mg_wdata;
                            5'h13: wdh = mg_wdata;
                            5'h14: mem[{wah, wal}] = {wdh, mg_wdata};
                            5'h15: rah = mg_wdata;
                            5'h16: ral = mg_wdata;
                            default: ;
                        endcase
                    end else phyreg[mg_phy][mg_reg] = mg_wdata;
                end else begin
                    if (mg_phy == SW && page_m[mg_phy] == 3'd4) begin
                        if (mg_reg == 5'h17) mg_rdata = mem_rd({rah, ral})[31:16];
                        else if (mg_reg == 5'h18) mg_rdata = mem_rd({rah, ral})[15:0];
                    end else mg_rdata = phyreg[mg_phy][mg_reg];
                end
            end
        end
    end

    logic        r_err;
    logic [31:0] r_rdata;

    task automatic run(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] d, input logic [31:0] m);
        int t;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready low after accept", {31'b0, req_ready}, 32'h0);
        t = 0;
        while (!rsp_done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_done == 1'b1, "R11", "response seen", {31'b0, rsp_done}, 32'h1);
        r_err = rsp_err;
        r_rdata = rsp_rdata;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11", "single done pulse", {31'b0, rsp_done}, 32'h0);
    endtask

    task automatic exp_txn(input int i, input logic w, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] dat, input string req);
        chk(lg_w[i] == w && lg_phy[i] == phy && lg_reg[i] == rg && (!w || lg_dat[i] == dat),
            req, $sformatf("txn %0d w/phy/reg/data", i),
            {lg_w[i], 1'b0, lg_phy[i], lg_reg[i], lg_dat[i][15:0]},
            {w, 1'b0, phy, rg, dat});
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] mask;
        logic [31:0] exp;
        logic [7:0]  n;
    } vec_t;

    localparam vec_t VEC [0:9] = '{
        '{3'd1, 32'h1000_5000, 32'h0000_8855, 32'h0, 32'h0,          8'd6},
        '{3'd0, 32'h1000_5000, 32'h0,         32'h0, 32'h0000_8855,  8'd6},
        '{3'd1, 32'h1021_C004, 32'hDEAD_BEEF, 32'h0, 32'h0,          8'd6},
        '{3'd2, 32'h1021_C004, 32'h0012_0000, 32'h00FF_0000, 32'h0,  8'd11},
        '{3'd0, 32'h1021_C004, 32'h0,         32'h0, 32'hDE12_BEEF,  8'd6},
        '{3'd4, 32'h0000_0044, 32'h0000_1234, 32'h0, 32'h0,          8'd1},
        '{3'd3, 32'h0000_0044, 32'h0,         32'h0, 32'h0000_1234,  8'd1},
        '{3'd4, 32'h0000_00A9, 32'h0000_BEEF, 32'h0, 32'h0,          8'd2},
        '{3'd3, 32'h0000_00A9, 32'h0,         32'h0, 32'h0000_BEEF,  8'd1},
        '{3'd0, 32'h1021_C004, 32'h0,         32'h0, 32'hDE12_BEEF,  8'd6}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1 && mg_valid == 1'b0 && rsp_done == 1'b0, "R1", "reset outputs",
            {29'b0, req_ready, mg_valid, rsp_done}, 32'h4);
        run(3'd3, 32'h0000_00A0, 32'h0, 32'h0);
        chk(log_n == 1, "R1", "page cache zero after reset", log_n, 1);

        // vector walk
        for (int i = 0; i < 10; i++) begin
            run(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].mask);
            chk(r_err == 1'b0, "R6", $sformatf("vec %0d no error", i), {31'b0, r_err}, 32'h0);
            chk(log_n == int'(VEC[i].n), "R5", $sformatf("vec %0d txn count", i), log_n, VEC[i].n);
            if (VEC[i].op == 3'd0 || VEC[i].op == 3'd3)
                chk(r_rdata == VEC[i].exp, "R4", $sformatf("vec %0d read data", i), r_rdata, VEC[i].exp);
        end

        // R2, R3 exact write order
        run(3'd1, 32'h2000_0000, 32'hFFFF_0000, 32'h0);
        exp_txn(0, 1, SW, 5'd31, 16'd4, "R2");
        exp_txn(1, 1, SW, 5'h10, 16'h0, "R3");
        exp_txn(2, 1, SW, 5'h11, 16'h2000, "R3");
        exp_txn(3, 1, SW, 5'h12, 16'h0000, "R3");
        exp_txn(4, 1, SW, 5'h13, 16'hFFFF, "R3");
        exp_txn(5, 1, SW, 5'h14, 16'h0000, "R3");

        // R4 exact read order
        run(3'd0, 32'h2000_0000, 32'h0, 32'h0);
        exp_txn(0, 1, SW, 5'd31, 16'd4, "R2");
        exp_txn(1, 1, SW, 5'h10, 16'h0, "R4");
        exp_txn(2, 1, SW, 5'h15, 16'h2000, "R4");
        exp_txn(3, 1, SW, 5'h16, 16'h0000, "R4");
        exp_txn(4, 0, SW, 5'h17, 16'h0, "R4");
        exp_txn(5, 0, SW, 5'h18, 16'h0, "R4");
        chk(r_rdata == 32'hFFFF_0000, "R4", "assembled word", r_rdata, 32'hFFFF_0000);

        // R5 masked update sequence
        run(3'd2, 32'h2000_0000, 32'h0A0A_0A0A, 32'hF0F0_F0F0);
        chk(log_n == 11, "R5", "update txn count", log_n, 11);
        exp_txn(5, 0, SW, 5'h18, 16'h0, "R5");
        exp_txn(6, 1, SW, 5'h10, 16'h0, "R5");
        exp_txn(7, 1, SW, 5'h11, 16'h2000, "R5");
        exp_txn(9, 1, SW, 5'h13, 16'h0F0F, "R5");
        exp_txn(10, 1, SW, 5'h14, 16'h0A0A, "R5");

        // R6 aborts
        err_at = 3;
        run(3'd1, 32'h2000_0000, 32'h1111_1111, 32'h0);
        chk(r_err == 1'b1, "R6", "write abort flag", {31'b0, r_err}, 32'h1);
        chk(log_n == 3, "R6", "write abort txn count", log_n, 3);
        err_at = 6;
        run(3'd2, 32'h2000_0000, 32'h0000_0001, 32'hFFFF_FFFF);
        chk(r_err == 1'b1 && log_n == 6, "R6", "update abort in read half", log_n, 6);
        run(3'd0, 32'h2000_0000, 32'h0, 32'h0);
        chk(r_err == 1'b1 && log_n == 6, "R6", "abort on final step", log_n, 6);
        err_at = 0;
        run(3'd0, 32'h2000_0000, 32'h0, 32'h0);
        chk(r_rdata == 32'h0F0F_0A0A, "R6", "word untouched by aborts", r_rdata, 32'h0F0F_0A0A);

        // R8, R9 other-address PHY write while bridge page cached
        run(3'd4, {22'b0, 5'd7, 5'd1}, 32'hABCD_0077, 32'h0);
        chk(log_n == 1, "R8", "direct forward count", log_n, 1);
        exp_txn(0, 1, 5'd7, 5'd1, 16'h0077, "R9");

        // R7, R9 shared-address PHY read restores page once
        run(3'd3, 32'h0000_00A9, 32'h0, 32'h0);
        chk(log_n == 2, "R7", "restore then access", log_n, 2);
        exp_txn(0, 1, SW, 5'd31, 16'd0, "R7");
        exp_txn(1, 0, SW, 5'd9, 16'h0, "R9");
        chk(r_rdata == 32'h0000_BEEF, "R9", "phy read upper zero", r_rdata, 32'h0000_BEEF);
        run(3'd3, 32'h0000_00A9, 32'h0, 32'h0);
        chk(log_n == 1, "R7", "no second restore", log_n, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule